// File: doc/BRIEF.md
# I2C Quad DAC Register Interface

This block is the two-wire serial slave that sits in front of a four-channel digital-to-analog converter's register file. It watches oversampled SCL and SDA lines in the system clock domain and answers a 7-bit device address. Six bits of that address are fixed and one comes from a strap pin, so two copies can share one bus. SDA is driven open-drain through an output enable, and an asserted enable pulls the line low.

A write transaction carries a channel-select byte and then any number of two-byte data words. Each low bit of the select byte picks one channel, and several may be set at once. After the second byte of a word has been acknowledged, the 16-bit word is stored into every selected channel. Its top bits carry a power-down mode, an active-low clear control, an active-low load control and left-justified 12-bit sample data. A read returns the stored word of one selected channel. The select byte for a read can come from a write earlier in the same transaction or from any earlier transaction.

Top module: `quad_dac_i2c_if`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0001100 with the last of those seven replaced by `addr_strap`, and the block pulls SDA low during the ninth clock. Bit 0 of the address byte selects the direction: 0 writes and 1 reads.
- R2: On an address that does not match, the block never drives SDA and changes no output until the next start condition, whatever bytes follow.
- R3: In a write, the first byte after the address is the channel select. Its bit 0 picks channel A, bit 1 picks B, bit 2 picks C and bit 3 picks D, and any combination is allowed. Bits 7:4 have no effect.
- R4: The next two bytes form one word, with the first byte as bits 15:8 and the second as bits 7:0. The word is stored to every selected channel, on `ch_word[16*i+15:16*i]` for channel i, only after the second byte has been acknowledged. A stop after only the first byte stores nothing.
- R5: Further byte pairs in the same write transaction are stored to the same selected channels.
- R6: `pd_mode` shows bits 15:14 of the most recently stored word.
- R7: A stored word with bit 13 equal to 0 gives exactly one `clr_stb` pulse, and one with bit 12 equal to 0 gives exactly one `ld_stb` pulse. Each pulse is one system clock long, and a 1 in either bit gives no pulse.
- R8: A read sends the stored word of the lowest-numbered selected channel, high byte first and then low byte, MSB first. While the master acknowledges, the bytes keep alternating high and low. With no channel selected, the read returns 0x0000.
- R9: A read that sends only the address uses the channel select stored by an earlier transaction, including a write that carried no data bytes.
- R10: When the master does not acknowledge a read byte, the block releases SDA and drives it no more before the next start.
- R11: The block changes `sda_oe` only while SCL is low.
- R12: After reset, all channel words are 0, `pd_mode` is 0, both strobes are low, `sda_oe` is low and the stored channel select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 1 | Selects the lowest bit of the device address |
| sda_oe | output | 1 | When high, the open-drain driver pulls SDA low |
| ch_word | output | 4*16 | Stored input word of each channel, channel A in bits 15:0 |
| pd_mode | output | 2 | Power-down mode bits of the last stored word |
| clr_stb | output | 1 | One-cycle clear strobe |
| ld_stb | output | 1 | One-cycle load strobe that updates all channels |

## Verification
Directed transactions cover several cases: single-channel and multi-channel selects with junk in the upper select bits, repeated word pairs, a select-only write followed by an address-only read, a read with an empty select, an abandoned word and both kinds of address mismatch. Together they separate the select decode from the commit point and from the pointer memory. Random writes then vary the select byte, the number of word pairs and the word values, with the clear and load bits random. They are checked against a bench model of every channel, the mode bits and the strobe counts, which catches wrong lanes, early commits and missing or extra pulses. Random reads, with and without a fresh select, check that the lowest selected channel is chosen and that the high and low bytes alternate in the right order.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PD_MSB = 15;
  localparam int PD_LSB = 14;
  localparam int CLR_BIT = 13;
  localparam int LD_BIT = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK, ST_SKIP
  } bus_st_t;

  // true when the received address byte names this device
  function automatic logic addr_hit(logic [BYTE_W-1:0] b, logic [5:0] hi, logic strap);
    return b[BYTE_W-1:1] == {hi, strap};
  endfunction
endpackage

// File: rtl/dac_i2c_sync.sv
module dac_i2c_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINE = 2;
  logic [NLINE-1:0] raw;
  logic [NLINE-1:0] s1, s2, s3;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g] <= 1'b1;
        s2[g] <= 1'b1;
        s3[g] <= 1'b1;
      end else begin
        s1[g] <= raw[g];
        s2[g] <= s1[g];
        s3[g] <= s2[g];
      end
    end
  end

  assign scl_q     = s2[0];
  assign sda_q     = s2[1];
  assign scl_rise  = s2[0] & ~s3[0];
  assign scl_fall  = ~s2[0] & s3[0];
  assign start_det = s3[1] & ~s2[1] & s2[0] & s3[0];
  assign stop_det  = ~s3[1] & s2[1] & s2[0] & s3[0];
endmodule

// File: rtl/dac_i2c_engine.sv
module dac_i2c_engine
  import dac_i2c_pkg::*;
#(
  parameter int NCH = 4,
  parameter logic [5:0] ADDR_HI = 6'b000110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              strap,
  input  logic [WORD_W-1:0] rd_word,
  output logic              sda_oe,
  output logic [NCH-1:0]    ptr,
  output logic              commit,
  output logic [WORD_W-1:0] commit_word,
  output logic [NCH-1:0]    commit_sel
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  bus_st_t            st;
  logic [CNT_W-1:0]   bcnt;
  logic [BYTE_W-1:0]  rx, tx, hi_byte;
  logic               rw, rd_lo, nack;
  logic [1:0]         phase;
  logic [BYTE_W-1:0]  next_tx;
  logic               byte_done;

  assign byte_done = scl_fall && (bcnt == LAST_BIT);
  assign next_tx   = rd_lo ? rd_word[BYTE_W-1:0] : rd_word[WORD_W-1:BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bcnt <= '0; rx <= '0; tx <= '0; hi_byte <= '0;
      rw <= 1'b0; rd_lo <= 1'b0; nack <= 1'b0; phase <= 2'd0;
      sda_oe <= 1'b0; ptr <= '0;
      commit <= 1'b0; commit_word <= '0; commit_sel <= '0;
    end else begin
      commit <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; bcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              rx <= {rx[BYTE_W-2:0], sda_q}; bcnt <= bcnt + 1'b1;
            end else if (byte_done) begin
              if (addr_hit(rx, ADDR_HI, strap)) begin
                st <= ST_AACK; sda_oe <= 1'b1; rw <= rx[0];
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bcnt <= '0;
            if (rw) begin
              st <= ST_RD; tx <= rd_word[WORD_W-1:BYTE_W];
              sda_oe <= ~rd_word[WORD_W-1]; rd_lo <= 1'b1;
            end else begin
              st <= ST_WR; sda_oe <= 1'b0; phase <= 2'd0;
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              rx <= {rx[BYTE_W-2:0], sda_q}; bcnt <= bcnt + 1'b1;
            end else if (byte_done) begin
              st <= ST_WACK; sda_oe <= 1'b1;
            end
          end
          ST_WACK: if (scl_fall) begin
            st <= ST_WR; sda_oe <= 1'b0; bcnt <= '0;
            unique case (phase)
              2'd0: begin ptr <= rx[NCH-1:0]; phase <= 2'd1; end
              2'd1: begin hi_byte <= rx; phase <= 2'd2; end
              default: begin
                commit <= 1'b1; commit_word <= {hi_byte, rx};
                commit_sel <= ptr; phase <= 2'd1;
              end
            endcase
          end
          ST_RD: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (byte_done) begin
              st <= ST_RACK; sda_oe <= 1'b0;
            end else if (scl_fall) begin
              tx <= {tx[BYTE_W-2:0], 1'b0}; sda_oe <= ~tx[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_q;
            end else if (scl_fall) begin
              if (nack) begin
                st <= ST_SKIP;
              end else begin
                st <= ST_RD; bcnt <= '0; tx <= next_tx;
                sda_oe <= ~next_tx[BYTE_W-1]; rd_lo <= ~rd_lo;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_oe); // R2
  AST_OE_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> $stable(sda_oe)); // R11
  AST_RACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK) |-> !sda_oe); // R10
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_i2c_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [NCH-1:0]        wr_sel,
  input  logic [WORD_W-1:0]     wr_word,
  output logic [NCH*WORD_W-1:0] ch_word,
  output logic [1:0]            pd_mode,
  output logic                  clr_stb,
  output logic                  ld_stb
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_word[c*WORD_W +: WORD_W] <= '0;
      else if (wr_en && wr_sel[c]) ch_word[c*WORD_W +: WORD_W] <= wr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_mode <= 2'b00; clr_stb <= 1'b0; ld_stb <= 1'b0;
    end else begin
      clr_stb <= wr_en & ~wr_word[CLR_BIT];
      ld_stb  <= wr_en & ~wr_word[LD_BIT];
      if (wr_en) pd_mode <= wr_word[PD_MSB:PD_LSB];
    end
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ch_word)); // R4
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> !clr_stb); // R7
  AST_LD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> !ld_stb); // R7
  AST_PD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pd_mode)); // R6
endmodule

// File: rtl/quad_dac_i2c_if.sv
module quad_dac_i2c_if
  import dac_i2c_pkg::*;
#(
  parameter int NCH = 4,
  parameter logic [5:0] ADDR_HI = 6'b000110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic                  addr_strap,
  output logic                  sda_oe,
  output logic [NCH*WORD_W-1:0] ch_word,
  output logic [1:0]            pd_mode,
  output logic                  clr_stb,
  output logic                  ld_stb
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [NCH-1:0] ptr, commit_sel;
  logic commit;
  logic [WORD_W-1:0] commit_word, rd_word;

  // lowest-numbered selected channel wins; empty select reads zero
  function automatic logic [WORD_W-1:0] read_pick(logic [NCH-1:0] sel,
                                                  logic [NCH*WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (sel[i]) r = w[i*WORD_W +: WORD_W];
    return r;
  endfunction

  assign rd_word = read_pick(ptr, ch_word);

  dac_i2c_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dac_i2c_engine #(.NCH(NCH), .ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .strap(addr_strap), .rd_word(rd_word),
    .sda_oe(sda_oe), .ptr(ptr), .commit(commit),
    .commit_word(commit_word), .commit_sel(commit_sel)
  );

  dac_chan_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_sel(commit_sel),
    .wr_word(commit_word), .ch_word(ch_word), .pd_mode(pd_mode),
    .clr_stb(clr_stb), .ld_stb(ld_stb)
  );

  AST_COMMIT_NEEDS_SELECT_OR_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_sel == '0) |=> $stable(ch_word)); // R3
endmodule

// File: tb/tb_quad_dac_i2c_if.sv
`timescale 1ns/1ps
module tb_quad_dac_i2c_if;
  localparam int Q = 5;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe, clr_stb, ld_stb;
  logic [63:0] ch_word;
  logic [1:0] pd_mode;
  wire sda_bus = sda_m & ~sda_oe;

  quad_dac_i2c_if dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .addr_strap(strap), .sda_oe(sda_oe), .ch_word(ch_word),
    .pd_mode(pd_mode), .clr_stb(clr_stb), .ld_stb(ld_stb)
  );

  int vecs = 0, bad = 0;
  int clr_n = 0, ld_n = 0, wide = 0, r11_viol = 0;
  bit oe_seen = 0, prev_clr = 0, prev_ld = 0, prev_scl = 1, prev_oe = 0;
  logic [15:0] exp_w [4];
  logic [3:0] exp_ptr;
  logic [1:0] exp_pd;
  int exp_clr = 0, exp_ld = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (clr_stb) clr_n++;
      if (ld_stb) ld_n++;
      if ((prev_clr && clr_stb) || (prev_ld && ld_stb)) wide++;
      if (scl_m && prev_scl && (sda_oe != prev_oe)) r11_viol++;
      if (sda_oe) oe_seen = 1;
    end
    prev_clr = clr_stb; prev_ld = ld_stb; prev_scl = scl_m; prev_oe = sda_oe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask
  task automatic i2c_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask
  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1; wq(); s = sda_bus; wq(); scl_m = 0; wq();
  endtask
  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask
  task automatic get_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(~m_ack, s);
  endtask

  function automatic logic [7:0] abyte(logic st, logic rw);
    return {6'b000110, st, rw};
  endfunction

  function automatic logic [15:0] exp_read(logic [3:0] p);
    logic [15:0] r = 16'h0;
    for (int i = 0; i < 4; i++)
      if (p[i]) begin r = exp_w[i]; break; end
    return r;
  endfunction

  task automatic model_word(logic [15:0] w);
    for (int c = 0; c < 4; c++) if (exp_ptr[c]) exp_w[c] = w;
    exp_pd = w[15:14];
    if (!w[13]) exp_clr++;
    if (!w[12]) exp_ld++;
  endtask

  task automatic check_all(string req);
    repeat (4) @(negedge clk);
    for (int c = 0; c < 4; c++) chk(req, {16'h0, ch_word[16*c +: 16]}, {16'h0, exp_w[c]});
    chk({req, " R6 pd"}, {30'h0, pd_mode}, {30'h0, exp_pd});
    chk({req, " R7 clr count"}, clr_n, exp_clr);
    chk({req, " R7 ld count"}, ld_n, exp_ld);
  endtask

  // write: pointer then npairs words; acks checked
  task automatic wr_xfer(logic [7:0] p, int npairs, logic [15:0] w0, logic [15:0] w1,
                         logic [15:0] w2, string req);
    logic a;
    logic [15:0] ws [3];
    ws[0] = w0; ws[1] = w1; ws[2] = w2;
    i2c_start();
    put_byte(abyte(strap, 1'b0), a); chk({req, " R1 addr ack"}, a, 0);
    put_byte(p, a); chk({req, " R3 ptr ack"}, a, 0);
    exp_ptr = p[3:0];
    for (int k = 0; k < npairs; k++) begin
      put_byte(ws[k][15:8], a);
      put_byte(ws[k][7:0], a); chk({req, " R4 data ack"}, a, 0);
      model_word(ws[k]);
    end
    i2c_stop();
  endtask

  task automatic rd_xfer(bit set_ptr, logic [7:0] p, int nbytes, string req);
    logic a;
    logic [7:0] b;
    logic [15:0] w;
    i2c_start();
    if (set_ptr) begin
      put_byte(abyte(strap, 1'b0), a);
      put_byte(p, a);
      exp_ptr = p[3:0];
      i2c_start();
    end
    put_byte(abyte(strap, 1'b1), a); chk({req, " R1 read addr ack"}, a, 0);
    w = exp_read(exp_ptr);
    for (int k = 0; k < nbytes; k++) begin
      get_byte(k != nbytes - 1, b);
      chk({req, " R8 byte"}, b, (k % 2 == 0) ? w[15:8] : w[7:0]);
    end
    wq();
    chk({req, " R10 released after nack"}, sda_oe, 0);
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic a;
    for (int c = 0; c < 4; c++) exp_w[c] = 16'h0;
    exp_ptr = 4'h0; exp_pd = 2'b00;
    void'($urandom(32'h5eed_0d1c));
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 words", ch_word[31:0], 0);
    chk("R12 words hi", ch_word[63:32], 0);
    chk("R12 pd", pd_mode, 0);
    chk("R12 oe", sda_oe, 0);
    chk("R12 strobes", {clr_stb, ld_stb}, 0);
    rd_xfer(0, 8'h00, 2, "R12 ptr zero");

    // single channel, load pulse only
    wr_xfer(8'h01, 1, 16'hA5C3, 16'h0, 16'h0, "R4 single");
    check_all("R4 single");
    // multi-select with junk upper bits, two pairs
    wr_xfer(8'hF6, 2, 16'h1234, 16'h3FFF, 16'h0, "R5 multi");
    check_all("R3 R5 multi");
    rd_xfer(1, 8'h06, 4, "R8 lowest of B,C");
    // pointer-only write, then address-only read
    i2c_start(); put_byte(abyte(strap, 0), a); put_byte(8'h08, a); i2c_stop();
    exp_ptr = 4'h8;
    check_all("R9 ptr-only no commit");
    rd_xfer(0, 8'h00, 2, "R9 addr-only D");
    wr_xfer(8'h08, 1, 16'hC00D, 16'h0, 16'h0, "R9 D");
    rd_xfer(0, 8'h00, 3, "R9 addr-only D again");
    rd_xfer(1, 8'h30, 2, "R8 empty select");

    // R2 mismatches
    for (int m = 0; m < 2; m++) begin
      oe_seen = 0;
      i2c_start();
      put_byte(m == 0 ? abyte(~strap, 0) : 8'hA0, a);
      chk("R2 no ack", a, 1);
      put_byte(8'h0F, a); put_byte(8'h00, a); put_byte(8'h00, a);
      i2c_stop();
      chk("R2 never driven", oe_seen, 0);
      check_all("R2 unchanged");
    end

    // R4 stop after high byte only
    i2c_start(); put_byte(abyte(strap, 0), a); put_byte(8'h01, a);
    put_byte(8'h00, a); i2c_stop();
    exp_ptr = 4'h1;
    check_all("R4 half word");

    // strap change
    strap = 1;
    wr_xfer(8'h02, 1, 16'h8FFF, 16'h0, 16'h0, "R1 strap one");
    check_all("R1 strap one");

    // random traffic
    for (int it = 0; it < 40; it++) begin
      logic [7:0] p;
      int np;
      p = 8'($urandom);
      np = 1 + ($urandom % 3);
      wr_xfer(p, np, 16'($urandom), 16'($urandom), 16'($urandom), "R5 rand");
      check_all("R4 rand");
      if (it % 3 == 0) rd_xfer(1, 8'($urandom), 2 + ($urandom % 3), "R8 rand");
      else if (it % 3 == 1) rd_xfer(0, 8'h00, 2, "R9 rand");
    end

    chk("R11 oe change while SCL high", r11_viol, 0);
    chk("R7 strobe width", wide, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule